// File: doc/BRIEF.md
# Hash message block assembler

This block is the input stage of a hash accelerator. Software or a DMA engine writes the message one 32-bit word at a time. The block collects the words into message blocks for a compression core. A byte-ordering control can reverse each written word before it is used. When the final-calculation strobe arrives, the block closes the message. It trims the last word to its valid bits, appends a single 1 bit and zero fill, and places the 64-bit message bit length in the last two words of the final block. The length is written most-significant byte first, or least-significant byte first when the little-endian length control is set.

The most recent word is always held back in a staging register. This lets a partial last word be trimmed even when it is the final word of a block. A block is therefore presented to the core once a later word, or the final strobe, has been accepted. The core takes blocks over a valid/ready handshake. While a block waits for the core, new writes are stalled. A synchronous clear input drops any message in progress.

Top module: `hash_block_assembler`

## Requirements
- R1: After reset, blk_valid_o and blk_last_o are 0 and wr_ready_o is 1.
- R2: Each group of BLK_WORDS consecutive accepted message words forms one block, with the first word in the most significant 32 bits of blk_data_o. The block is presented after a later word write or the final strobe is accepted.
- R3: With byte_swap_i = 1, bits 7:0 of a written word become message bits 31:24, and so on (byte order reversed). With 0 the word is used unchanged. In both cases message bit order within a word runs from bit 31 downwards.
- R4: last_bits_i, captured when the final strobe is accepted, gives the number of valid bits in the last written word (1 to 31, with 0 meaning all 32). Only the top that-many bits are kept, and the rest are zero.
- R5: A single 1 bit is placed directly after the last message bit. It is followed by zeros up to the length field.
- R6: The final block's last two words hold the message length in bits as 64 bits. The most significant byte comes first when len_le_i = 0, and the least significant byte comes first when len_le_i = 1. len_le_i is captured with the final strobe.
- R7: If fewer than 65 bits of the current block remain after the message, one extra padding block follows. blk_last_o is 1 only with the final block.
- R8: While blk_valid_o = 1 and blk_ready_i = 0, blk_valid_o, blk_data_o and blk_last_o hold and wr_ready_o is 0. A write with wr_ready_o = 0 is not taken.
- R9: init_i = 1 discards the message in progress, including a pending block, and the next message's length counts from zero.
- R10: From acceptance of the final strobe (final_i = 1, wr_ready_o = 1, wr_en_i = 0) until the final block is taken, wr_ready_o is 0 and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Synchronous clear of the message in progress |
| wr_en_i | input | 1 | Data word write request |
| wr_data_i | input | 32 | Data word |
| byte_swap_i | input | 1 | Reverse byte order of written words |
| last_bits_i | input | 5 | Valid bits in last word, 0 means 32 |
| len_le_i | input | 1 | Length field least significant byte first |
| final_i | input | 1 | Final-calculation strobe |
| wr_ready_o | output | 1 | Write accepted this cycle when high |
| blk_valid_o | output | 1 | Block available to the core |
| blk_ready_i | input | 1 | Core takes the block |
| blk_data_o | output | 32*BLK_WORDS | Block, first word most significant |
| blk_last_o | output | 1 | Block is the final one of the message |

## Verification
The bench builds the block with BLK_WORDS = 4, which gives 128-bit blocks. With blocks this short, every message length from 0 to 259 bits runs through one, two and three output blocks. Those lengths also cover every position of the pad bit inside a word, and every case where the length field spills into an extra block. The sweep covers both byte orders and both length orders. The core's ready is toggled so that blocks stall. Junk words are written during padding and after a clear, and must not appear in the output.

// File: rtl/hba_pkg.sv
package hba_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 64;
  localparam int NB_W   = 5;

  typedef enum logic {ST_MSG, ST_PAD} hba_st_e;

  function automatic logic [WORD_W-1:0] rev_bytes32(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W/8; i++) r[8*i +: 8] = w[WORD_W-8-8*i +: 8];
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] rev_bytes64(input logic [LEN_W-1:0] v);
    logic [LEN_W-1:0] r;
    for (int i = 0; i < LEN_W/8; i++) r[8*i +: 8] = v[LEN_W-8-8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/hba_swap.sv
module hba_swap
  import hba_pkg::*;
(
  input  logic              en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int NBYTES = WORD_W / 8;
  logic [WORD_W-1:0] rev;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign rev[8*g +: 8] = word_i[WORD_W-8-8*g +: 8];
  end

  assign word_o = en_i ? rev : word_i;
endmodule

// File: rtl/hba_tail.sv
module hba_tail
  import hba_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [NB_W-1:0]   nbits_i,
  output logic [WORD_W-1:0] word_o,
  output logic [NB_W:0]     nb_o,
  output logic              padded_o
);
  logic              full;
  logic [WORD_W-1:0] keep;
  logic [WORD_W-1:0] one;

  assign full     = (nbits_i == '0);
  assign nb_o     = full ? (NB_W+1)'(WORD_W) : {1'b0, nbits_i};
  // top nbits kept; pad bit lands just below them
  assign keep     = full ? '1 : ~({WORD_W{1'b1}} >> nbits_i);
  assign one      = full ? '0 : ({1'b1, {(WORD_W-1){1'b0}}} >> nbits_i);
  assign word_o   = (word_i & keep) | one;
  assign padded_o = !full;
endmodule

// File: rtl/hba_buf.sv
module hba_buf
  import hba_pkg::*;
#(
  parameter int BLK_WORDS = 16,
  localparam int IDX_W = $clog2(BLK_WORDS),
  localparam int BLK_W = BLK_WORDS * WORD_W
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wrap_o,
  output logic [BLK_W-1:0]  data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_WORDS - 1);

  logic [WORD_W-1:0] mem_q [BLK_WORDS];
  logic [IDX_W-1:0]  idx_q;

  assign wrap_o = wr_i && (idx_q == LAST_IDX);
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (wr_i) begin
      idx_q <= wrap_o ? '0 : idx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_i && idx_q == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
    assign data_o[BLK_W-WORD_W-WORD_W*g +: WORD_W] = mem_q[g];
  end

  // R2: write index wraps to zero after the last slot
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && !clr_i |=> idx_q == '0);
endmodule

// File: rtl/hash_block_assembler.sv
module hash_block_assembler
  import hba_pkg::*;
#(
  parameter int BLK_WORDS = 16,
  localparam int IDX_W = $clog2(BLK_WORDS),
  localparam int BLK_W = BLK_WORDS * WORD_W
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              byte_swap_i,
  input  logic [NB_W-1:0]   last_bits_i,
  input  logic              len_le_i,
  input  logic              final_i,
  output logic              wr_ready_o,
  output logic              blk_valid_o,
  input  logic              blk_ready_i,
  output logic [BLK_W-1:0]  blk_data_o,
  output logic              blk_last_o
);
  localparam logic [IDX_W-1:0] LEN_HI_IDX = IDX_W'(BLK_WORDS - 2);

  hba_st_e           st_q;
  logic [WORD_W-1:0] stage_q;
  logic              stage_v_q;
  logic [LEN_W-1:0]  bitcnt_q;
  logic              one_q, lenhi_q;
  logic [NB_W-1:0]   nb_q;
  logic              le_q;
  logic              valid_q, last_q;

  logic [WORD_W-1:0] swap_w, tail_w, cdata;
  logic [NB_W:0]     tail_nb, add_bits;
  logic              tail_pad;
  logic              acc_wr, go_pad, commit, set_one, set_len, last_w;
  logic [IDX_W-1:0]  idx;
  logic              wrap;
  logic [LEN_W-1:0]  len_f;

  hba_swap u_swap (
    .en_i   (byte_swap_i),
    .word_i (wr_data_i),
    .word_o (swap_w)
  );

  hba_tail u_tail (
    .word_i   (stage_q),
    .nbits_i  (nb_q),
    .word_o   (tail_w),
    .nb_o     (tail_nb),
    .padded_o (tail_pad)
  );

  hba_buf #(.BLK_WORDS(BLK_WORDS)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (init_i),
    .wr_i    (commit && !init_i),
    .wdata_i (cdata),
    .idx_o   (idx),
    .wrap_o  (wrap),
    .data_o  (blk_data_o)
  );

  assign wr_ready_o  = (st_q == ST_MSG) && !valid_q;
  assign blk_valid_o = valid_q;
  assign blk_last_o  = last_q;
  assign acc_wr      = wr_en_i && wr_ready_o;
  assign go_pad      = final_i && wr_ready_o && !wr_en_i;
  assign len_f       = le_q ? rev_bytes64(bitcnt_q) : bitcnt_q;

  always_comb begin
    commit   = 1'b0;
    cdata    = '0;
    add_bits = '0;
    set_one  = 1'b0;
    set_len  = 1'b0;
    last_w   = 1'b0;
    if (st_q == ST_MSG) begin
      if (acc_wr && stage_v_q) begin
        commit   = 1'b1;
        cdata    = stage_q;
        add_bits = (NB_W+1)'(WORD_W);
      end
    end else if (!valid_q) begin
      commit = 1'b1;
      if (stage_v_q) begin
        cdata    = tail_w;
        add_bits = tail_nb;
        set_one  = tail_pad;
      end else if (!one_q) begin
        cdata   = {1'b1, {(WORD_W-1){1'b0}}};
        set_one = 1'b1;
      end else if (lenhi_q) begin
        cdata  = len_f[WORD_W-1:0];
        last_w = 1'b1;
      end else if (idx == LEN_HI_IDX) begin
        cdata   = len_f[LEN_W-1:WORD_W];
        set_len = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_MSG;
      stage_q   <= '0;
      stage_v_q <= 1'b0;
      bitcnt_q  <= '0;
      one_q     <= 1'b0;
      lenhi_q   <= 1'b0;
      nb_q      <= '0;
      le_q      <= 1'b0;
      valid_q   <= 1'b0;
      last_q    <= 1'b0;
    end else if (init_i) begin
      st_q      <= ST_MSG;
      stage_v_q <= 1'b0;
      bitcnt_q  <= '0;
      one_q     <= 1'b0;
      lenhi_q   <= 1'b0;
      valid_q   <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      if (acc_wr) begin
        stage_q   <= swap_w;
        stage_v_q <= 1'b1;
      end
      if (go_pad) begin
        st_q <= ST_PAD;
        nb_q <= last_bits_i;
        le_q <= len_le_i;
      end
      if (commit) begin
        bitcnt_q <= bitcnt_q + LEN_W'(add_bits);
        if (st_q == ST_PAD && stage_v_q) stage_v_q <= 1'b0;
        if (set_one) one_q   <= 1'b1;
        if (set_len) lenhi_q <= 1'b1;
        if (wrap) begin
          valid_q <= 1'b1;
          last_q  <= last_w;
        end
      end else if (valid_q && blk_ready_i) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
        if (last_q) begin
          st_q     <= ST_MSG;
          bitcnt_q <= '0;
          one_q    <= 1'b0;
          lenhi_q  <= 1'b0;
        end
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o && !blk_ready_i && !init_i |=>
      blk_valid_o && $stable(blk_data_o) && $stable(blk_last_o));

  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |-> !wr_ready_o);

  p_pad_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    final_i && wr_ready_o && !wr_en_i && !init_i |=> !wr_ready_o);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !blk_valid_o && !blk_last_o && wr_ready_o);

  p_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_last_o |-> blk_valid_o);
endmodule

// File: tb/hash_block_assembler_tb.sv
module hash_block_assembler_tb;
  localparam int NW = 4;
  localparam int BB = NW * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init = 1'b0, wr_en = 1'b0, byte_swap = 1'b0, len_le = 1'b0, fin = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [4:0]    last_bits = '0;
  logic          wr_ready, blk_valid, blk_ready, blk_last;
  logic [BB-1:0] blk_data;

  always #10 clk = ~clk;

  hash_block_assembler #(.BLK_WORDS(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .byte_swap_i(byte_swap), .last_bits_i(last_bits), .len_le_i(len_le), .final_i(fin),
    .wr_ready_o(wr_ready), .blk_valid_o(blk_valid), .blk_ready_i(blk_ready),
    .blk_data_o(blk_data), .blk_last_o(blk_last)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit reported = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [BB-1:0] cap [8];
  bit            capl [8];
  int            ncap = 0;
  bit            done_f = 0, hold_rdy = 0, skip_stall = 0, stall_prev = 0;
  logic [BB-1:0] stall_data;

  task automatic check(input bit ok, input string tag, input logic [BB-1:0] act, input logic [BB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] msgword(input int i, input int len);
    logic [31:0] a, b;
    a = 32'(i + 1) * 32'h9E37_79B9;
    b = 32'(len) * 32'h0001_0203;
    return a ^ b;
  endfunction

  function automatic logic [BB-1:0] exp_blk(input int len, input int j, input bit le);
    logic [BB-1:0] r;
    logic [63:0]   lv;
    logic [31:0]   w;
    logic [7:0]    by;
    int nb, tot, p, q, bi;
    bit b;
    nb  = (len + 64) / BB + 1;
    tot = nb * BB;
    lv  = 64'(len);
    for (int k = 0; k < BB; k++) begin
      p = j * BB + k;
      if (p < len) begin
        w = msgword(p / 32, len);
        b = w[31 - (p % 32)];
      end else if (p == len) begin
        b = 1'b1;
      end else if (p >= tot - 64) begin
        q  = p - (tot - 64);
        bi = q / 8;
        by = le ? lv[8*bi +: 8] : lv[8*(7-bi) +: 8];
        b  = by[7 - (q % 8)];
      end else begin
        b = 1'b0;
      end
      r[BB-1-k] = b;
    end
    return r;
  endfunction

  // core side: ready pattern, capture and hold check (R8)
  initial begin
    blk_ready = 1'b0;
    forever begin
      @(negedge clk);
      blk_ready = !hold_rdy && (cyc % 4 != 1);
      #1;
      if (stall_prev && !skip_stall)
        check(blk_valid && blk_data == stall_data, "R8 hold", blk_data, stall_data);
      stall_prev = blk_valid && !blk_ready;
      stall_data = blk_data;
      if (blk_valid && blk_ready && ncap < 8) begin
        cap[ncap]  = blk_data;
        capl[ncap] = blk_last;
        ncap++;
        if (blk_last) done_f = 1;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog act=running exp=finished");
    report();
  end

  task automatic wr_word(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    #2;
    while (!wr_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic run_msg(input int len, input bit le, input bit sw, input string tag);
    int nw, nexp;
    ncap = 0;
    done_f = 0;
    byte_swap = sw;
    nw = (len + 31) / 32;
    for (int i = 0; i < nw; i++)
      wr_word(sw ? bswap(msgword(i, len)) : msgword(i, len));
    @(negedge clk);
    last_bits = 5'(len % 32);
    len_le = le;
    fin = 1'b1;
    #2;
    while (!wr_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    fin = 1'b0;
    last_bits = 5'd7;
    len_le = !le;
    wr_en = 1'b1;
    wr_data = 32'hDEAD_BEEF;
    while (!done_f) begin
      @(negedge clk);
      #2;
      if (done_f) break;
      check(!wr_ready, "R10 busy", BB'(wr_ready), '0);
    end
    wr_en = 1'b0;
    @(posedge clk);
    #1;
    nexp = (len + 64) / BB + 1;
    check(ncap == nexp, {tag, " R7 count"}, BB'(ncap), BB'(nexp));
    for (int j = 0; j < ncap && j < 8; j++) begin
      check(cap[j] == exp_blk(len, j, le), tag, cap[j], exp_blk(len, j, le));
      check(capl[j] == (j == nexp - 1), "R7 last flag", BB'(capl[j]), BB'(j == nexp - 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(!blk_valid && wr_ready && !blk_last, "R1 reset", {blk_valid, wr_ready, blk_last}, 3'b010);

    // R9: pending block and staged word dropped by clear
    hold_rdy = 1;
    for (int i = 0; i < NW + 1; i++) wr_word(32'hA5A5_0000 + 32'(i));
    @(negedge clk);
    #2;
    check(blk_valid && !wr_ready, "R2 block pending", {blk_valid, wr_ready}, 2'b10);
    skip_stall = 1;
    init = 1'b1;
    @(posedge clk);
    #1;
    init = 1'b0;
    @(negedge clk);
    #2;
    check(!blk_valid && wr_ready, "R9 cleared", {blk_valid, wr_ready}, 2'b01);
    hold_rdy = 0;
    @(negedge clk);
    #2;
    skip_stall = 0;
    run_msg(100, 1'b0, 1'b0, "R9 restart");

    // sweep: R2 R3 R4 R5 R6 R7
    for (int le = 0; le < 2; le++)
      for (int sw = 0; sw < 2; sw++)
        for (int len = 0; len < 260; len++)
          run_msg(len, le[0], sw[0],
                  $sformatf("R2/R3/R4/R5/R6 len=%0d le=%0d sw=%0d", len, le, sw));
    report();
  end
endmodule